// File: doc/BRIEF.md
# Microwire Serial Word Memory Slave

This block is a synthesizable slave for a 3-wire Microwire-style serial memory holding 64 words of 16 bits. A host raises the select line and clocks in a frame on the serial data input. The frame is a start bit, a 2-bit operation code and a 6-bit word address, sent most significant bit first. The block answers on a single serial data output. It supports reading, writing, and commands that set and clear a write lock. A sequential read keeps streaming words for as long as select stays high.

All serial inputs are sampled by a free-running system clock that must be much faster than the serial clock. The block acts on each rising edge of the serial clock that it sees. After an accepted write, the output shows a busy level for a fixed number of system-clock cycles. This lets the host poll the output for completion.

Top module: `microwireEeprom`

## Requirements
- R1: Zero bits sampled on the data input while waiting for a frame are ignored. A frame starts with a 1, then a 2-bit operation code, then 6 address bits, all most significant bit first.
- R2: Operation code 10 is a read. On the rising serial clock edge that captures the last address bit, the output goes to a dummy 0. Each of the next 16 rising edges presents one data bit, most significant bit first.
- R3: During a read with select held high, the rising edge after bit 0 of a word presents the most significant bit of the word at the next address, with no dummy bit. Address 63 is followed by address 0.
- R4: After reset every word reads as 0x0000 and writes are locked.
- R5: Operation code 00 with the two leading address bits 11 clears the write lock. Operation code 00 with the two leading address bits 00 sets the lock again. Reads behave the same whatever the lock state.
- R6: Operation code 01 is a write and is followed by 16 data bits. The word is stored on the rising edge of the last data bit, and only when the lock is clear. A locked write changes no word and starts no busy period.
- R7: An accepted write makes the output 0 (busy) for BUSY_CYCLES system-clock cycles, then 1 (ready), whenever no read is streaming. Start bits that arrive while busy are ignored.
- R8: Pulling select low aborts any partial frame and returns the block to waiting for a start bit. An aborted write stores nothing. Outside a read, the output shows the ready/busy level.
- R9: While a read streams, the output changes only on a rising edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rstN | input | 1 | Active-low synchronous reset |
| chipSel | input | 1 | Select, active high |
| serClk | input | 1 | Serial clock from the host |
| serIn | input | 1 | Serial data from the host |
| serOut | output | 1 | Serial read data, or the ready/busy level |

## Verification
The hardest case to reach is a start bit that arrives while a write is still busy. From outside, an ignored read frame looks almost the same as a real read, because both show a 0 right after the address. The stimulus writes a word whose top bit is 1, keeps select high, and clocks a full read frame to that word. It then clocks two more bits while the busy window is still open. A genuine read would show a 1 there, but the correct design holds 0 until the busy window ends. Streaming across the top address into word 0 is also covered by writing both end words first.

// File: rtl/mwPkg.sv
package mwPkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_WDATA,
    PH_READ,
    PH_SINK
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic latchAddr;
    logic loadRead;
    logic shiftOut;
    logic loadNext;
    logic writeMem;
    logic readMode;
    logic ready;
  } strobes_t;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mwCtrl.sv
module mwCtrl
  import mwPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              serClk,
  input  logic              serIn,
  input  logic [ADDR_W+1:0] cmdWord,
  output strobes_t          strb,
  output phase_t            phase,
  output logic              sclkRise,
  output logic              wen,
  output logic              busy
);
  localparam int CMD_W  = ADDR_W + 2;
  localparam int CNT_W  = $clog2(DATA_W) + 1;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic              serClkQ;
  logic [CNT_W-1:0]  cnt, nCnt;
  logic [BUSY_W-1:0] busyCnt;
  phase_t            nPhase;
  logic              nWen, startBusy;
  logic [1:0]        opCode, modeBits;

  assign sclkRise = serClk & ~serClkQ;
  assign busy     = (busyCnt != '0);
  assign opCode   = cmdWord[CMD_W-1 -: 2];
  assign modeBits = cmdWord[ADDR_W-1 -: 2];

  always_comb begin
    strb          = '0;
    strb.readMode = (phase == PH_READ);
    strb.ready    = ~busy;
    nPhase        = phase;
    nCnt          = cnt;
    nWen          = wen;
    startBusy     = 1'b0;
    if (!chipSel) begin
      nPhase = PH_IDLE;
      nCnt   = '0;
    end else if (sclkRise) begin
      unique case (phase)
        PH_IDLE: if (serIn && !busy) begin
          nPhase = PH_CMD;
          nCnt   = '0;
        end
        PH_CMD: begin
          strb.shiftIn = 1'b1;
          nCnt = cnt + 1'b1;
          if (cnt == CNT_W'(CMD_W - 1)) begin
            nCnt = '0;
            nPhase = PH_SINK;
            if (opCode == OP_READ) begin
              strb.loadRead  = 1'b1;
              strb.latchAddr = 1'b1;
              nPhase = PH_READ;
            end else if (opCode == OP_WRITE) begin
              strb.latchAddr = 1'b1;
              nPhase = PH_WDATA;
            end else if (opCode == OP_MISC) begin
              if (modeBits == 2'b11) nWen = 1'b1;
              else if (modeBits == 2'b00) nWen = 1'b0;
            end
          end
        end
        PH_WDATA: begin
          strb.shiftIn = 1'b1;
          nCnt = cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W - 1)) begin
            nPhase = PH_SINK;
            if (wen) begin
              strb.writeMem = 1'b1;
              startBusy = 1'b1;
            end
          end
        end
        PH_READ: begin
          if (cnt == CNT_W'(DATA_W - 1)) begin
            strb.loadNext = 1'b1;
            nCnt = '0;
          end else begin
            strb.shiftOut = 1'b1;
            nCnt = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serClkQ <= 1'b0;
      phase   <= PH_IDLE;
      cnt     <= '0;
      wen     <= 1'b0;
      busyCnt <= '0;
    end else begin
      serClkQ <= serClk;
      phase   <= nPhase;
      cnt     <= nCnt;
      wen     <= nWen;
      if (startBusy) busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/mwDatapath.sv
module mwDatapath
  import mwPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  strobes_t          strb,
  output logic [ADDR_W+1:0] cmdWord,
  output logic              serOut
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] inShift, dataSh, wrData;
  logic [ADDR_W-1:0] addr, addrNext;
  logic              outBit;

  assign cmdWord  = {inShift[CMD_W-2:0], serIn};
  assign wrData   = {inShift[DATA_W-2:0], serIn};
  assign addrNext = addr + 1'b1;
  assign serOut   = strb.readMode ? outBit : strb.ready;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift <= '0;
      dataSh  <= '0;
      addr    <= '0;
      outBit  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.shiftIn) inShift <= wrData;
      if (strb.latchAddr) addr <= cmdWord[ADDR_W-1:0];
      if (strb.loadRead) begin
        outBit <= 1'b0;
        dataSh <= mem[cmdWord[ADDR_W-1:0]];
      end
      if (strb.shiftOut) begin
        outBit <= dataSh[DATA_W-1];
        dataSh <= dataSh << 1;
      end
      if (strb.loadNext) begin
        outBit <= dataSh[DATA_W-1];
        dataSh <= mem[addrNext];
        addr   <= addrNext;
      end
      if (strb.writeMem) mem[addr] <= wrData;
    end
  end
endmodule

// File: rtl/microwireEeprom.sv
module microwireEeprom
  import mwPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic serIn,
  output logic serOut
);
  strobes_t          strb;
  phase_t            phase;
  logic              sclkRise, wen, busy;
  logic [ADDR_W+1:0] cmdWord;

  mwCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk), .serIn(serIn),
    .cmdWord(cmdWord), .strb(strb), .phase(phase), .sclkRise(sclkRise),
    .wen(wen), .busy(busy)
  );

  mwDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strb(strb),
    .cmdWord(cmdWord), .serOut(serOut)
  );
endmodule

// File: rtl/mwChecker.sv
module mwChecker
  import mwPkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   chipSel,
  input logic   serOut,
  input phase_t phase,
  input logic   sclkRise,
  input logic   wen,
  input logic   busy,
  input logic   writeMem,
  input logic   loadRead
);
  AST_DESELECT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> phase == PH_IDLE); // R8

  AST_LOCKED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !wen); // R4

  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    writeMem |-> wen); // R6

  AST_BUSY_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase != PH_READ) |-> !serOut); // R7

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase == PH_IDLE) |=> phase == PH_IDLE); // R7

  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    loadRead |=> (phase == PH_READ && !serOut)); // R2

  AST_OUT_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_READ && chipSel && !sclkRise) |=> $stable(serOut)); // R9
endmodule

bind microwireEeprom mwChecker uChk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .serOut(serOut),
  .phase(phase), .sclkRise(sclkRise), .wen(wen), .busy(busy),
  .writeMem(strb.writeMem), .loadRead(strb.loadRead)
);

// File: tb/sim_microwireEeprom.sv
module sim_microwireEeprom;
  localparam int BUSY = 400;

  logic clk = 1'b0, rstN = 1'b0, chipSel = 1'b0, serClk = 1'b0, serIn = 1'b0;
  logic serOut;
  int   nRun = 0, nFail = 0;
  bit   done = 1'b0;

  typedef struct { logic val; string req; } exp_t;
  exp_t expQ[$];
  event sampleEv;

  always #10 clk = ~clk;

  microwireEeprom #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk),
    .serIn(serIn), .serOut(serOut)
  );

  // monitor: compares the output against queued expectations
  always @(sampleEv) begin
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      nRun++;
      if (serOut !== e.val) begin
        nFail++;
        $display("FAIL %s: serOut=%0b expected %0b at %0t", e.req, serOut, e.val, $time);
      end
    end
  end

  task automatic expectBit(input logic v, input string r);
    expQ.push_back('{v, r});
    ->sampleEv;
    @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    serIn = d;
    repeat (2) @(negedge clk);
    serClk = 1'b1;
    repeat (2) @(negedge clk);
    serClk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect();
    chipSel = 1'b0;
    repeat (3) @(negedge clk);
    chipSel = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [5:0] a);
    pulse(1'b1);
    for (int i = 1; i >= 0; i--) pulse(op[i]);
    for (int i = 5; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic readWords(input logic [5:0] a, input int n,
                           input logic [15:0] w0, input logic [15:0] w1, input string r);
    sendCmd(2'b10, a);
    expectBit(1'b0, r);
    for (int k = 0; k < n; k++) begin
      for (int b = 15; b >= 0; b--) begin
        pulse(1'b0);
        expectBit(k == 0 ? w0[b] : w1[b], r);
      end
    end
    deselect();
  endtask

  task automatic writeWord(input logic [5:0] a, input logic [15:0] d);
    sendCmd(2'b01, a);
    for (int b = 15; b >= 0; b--) pulse(d[b]);
    deselect();
  endtask

  task automatic waitReady();
    repeat (BUSY + 10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chipSel = 1'b1;
    repeat (2) @(negedge clk);

    // R4: ready level after reset, memory cleared
    expectBit(1'b1, "R4 ready after reset");
    readWords(6'd5, 1, 16'h0000, 16'h0, "R4 word cleared");

    // R6: write while locked has no effect and no busy
    writeWord(6'd3, 16'hA5C3);
    expectBit(1'b1, "R6 locked write starts no busy");
    readWords(6'd3, 1, 16'h0000, 16'h0, "R6 locked write stores nothing");

    // R5: clear lock, then R6/R7 accepted write and busy window
    sendCmd(2'b00, 6'b110000); deselect();
    writeWord(6'd3, 16'hA5C3);
    expectBit(1'b0, "R7 busy after write");
    sendCmd(2'b10, 6'd3);
    pulse(1'b0); expectBit(1'b0, "R7 start ignored while busy");
    pulse(1'b0); expectBit(1'b0, "R7 start ignored while busy");
    waitReady();
    expectBit(1'b1, "R7 ready after busy window");
    deselect();
    readWords(6'd3, 1, 16'hA5C3, 16'h0, "R2 read back written word");

    // R3: stream across the top address into word 0
    writeWord(6'd63, 16'h1234); waitReady();
    writeWord(6'd0, 16'hBEEF); waitReady();
    readWords(6'd63, 2, 16'h1234, 16'hBEEF, "R3 sequential wrap 63 to 0");
    readWords(6'd3, 2, 16'hA5C3, 16'h0000, "R3 sequential next word");

    // R1: leading zeros before the start bit
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    readWords(6'd0, 1, 16'hBEEF, 16'h0, "R1 leading zeros ignored");

    // R8: abort partial frame, then abort partial write
    pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b1);
    deselect();
    readWords(6'd63, 1, 16'h1234, 16'h0, "R8 abort then fresh frame");
    sendCmd(2'b01, 6'd5);
    for (int b = 0; b < 8; b++) pulse(1'b1);
    deselect();
    expectBit(1'b1, "R8 aborted write not busy");
    readWords(6'd5, 1, 16'h0000, 16'h0, "R8 aborted write stores nothing");

    // R9: output holds between serial edges
    sendCmd(2'b10, 6'd0);
    expectBit(1'b0, "R9 dummy bit present");
    repeat (20) @(negedge clk);
    expectBit(1'b0, "R9 no change without serial edge");
    pulse(1'b0);
    repeat (20) @(negedge clk);
    expectBit(1'b1, "R9 bit held until next edge");
    deselect();

    // R5: set lock again, write refused, read unaffected
    sendCmd(2'b00, 6'b001111); deselect();
    writeWord(6'd0, 16'h0000);
    expectBit(1'b1, "R5 locked again no busy");
    readWords(6'd0, 1, 16'hBEEF, 16'h0, "R5 lock blocks write, read works");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule